// File: doc/BRIEF.md
# Column Hit Packer with Multi-Write FIFO

This block sits between a column-sweeping pixel readout and a serial hit stream. Each cycle it may receive the row vector of one enabled pixel column along with that column's position (a sub-column index inside a group of four columns, and the group index) and the current timestamp. Every set bit of the row vector becomes one 12-bit hit word in that same cycle. All of these words go into a 16-entry circular buffer, one write slot per row, so a column with any number of hits is absorbed in one step.

The output side works in data-push fashion. Whenever the buffer holds data, one word is popped per cycle and presented with a valid flag. No request or trigger input is involved. When free space drops below one full column, a stall output tells the upstream sweep to pause. A column presented during stall is not taken, so the upstream logic never has a hit dropped silently.

Top module: `hit_packer_fifo`

## Requirements
- R1: While and right after reset, `out_valid`, `stall` and `out_hit` are all 0 and the buffer is empty.
- R2: Each hit word is laid out as bits [11:9] = row index (the bit position in `col_rows`), [8:7] = `sub_col`, [6:4] = `mc_idx`, [3:0] = `ts`, all taken from the cycle the column was accepted.
- R3: A column accepted at one clock edge has all of its set bits stored at that edge, whatever their number (0 to 8). Its words leave the block in ascending row order.
- R4: With an empty buffer, a column accepted at edge k shows its first word with `out_valid`=1 after edge k+1. Its remaining words follow one per cycle with no gap.
- R5: Words leave in the order they were accepted across columns. Storage wraps modulo 16 with no loss or reordering.
- R6: `stall` is 1 exactly when the occupancy (words accepted and not yet output) exceeds 8, that is, when free space is below 8.
- R7: A column presented with `col_valid`=1 while `stall`=1 is ignored: none of its words ever appear on the output.
- R8: In a cycle where no word is popped, `out_valid` is 0 and `out_hit` keeps its previous value.
- R9: An accepted column whose row vector is 0 adds no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| col_valid | input | 1 | A column row vector is presented this cycle |
| col_rows | input | 8 | Hit flag per pixel row of the enabled column |
| sub_col | input | 2 | Column position inside its group of four |
| mc_idx | input | 3 | Column group index |
| ts | input | 4 | Timestamp attached to the column's hits |
| stall | output | 1 | Free space below one full column; upstream must pause |
| out_valid | output | 1 | `out_hit` carries a new word this cycle |
| out_hit | output | 12 | Encoded hit word |

## Verification
The main function is exercised with several row patterns. A lone set bit checks the field positions and the two-edge latency. A full column checks the eight-slot write and the ascending order. An all-zero column must add nothing. Two sparse, interleaved patterns sent back to back check the slot ranking and the ordering across columns. A run of full columns drives the occupancy past 8, which checks that stall rises at the right count and that columns offered during stall never show up. The write and read pointers also wrap several times in this run. Idle stretches between scenarios check that the output word holds while `out_valid` is low.

// File: rtl/hit_packer_fifo.sv
module hit_packer_fifo #(
  parameter int ROWS  = 8,
  parameter int SUB_W = 2,
  parameter int MC_W  = 3,
  parameter int TS_W  = 4,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  col_valid,
  input  logic [ROWS-1:0]       col_rows,
  input  logic [SUB_W-1:0]      sub_col,
  input  logic [MC_W-1:0]       mc_idx,
  input  logic [TS_W-1:0]       ts,
  output logic                  stall,
  output logic                  out_valid,
  output logic [$clog2(ROWS)+SUB_W+MC_W+TS_W-1:0] out_hit
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int HIT_W = ROW_W + SUB_W + MC_W + TS_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int RW    = ROW_W + 1;
  localparam logic [CW-1:0] STALL_AT = CW'(DEPTH - ROWS);

  logic [HIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic [RW-1:0]    rank [ROWS];
  logic [RW-1:0]    n_hits;

  assign stall = cnt > STALL_AT;
  wire accept = col_valid && !stall;
  wire pop    = cnt != '0;

  always_comb begin
    n_hits = '0;
    for (int i = 0; i < ROWS; i++) begin
      rank[i] = n_hits;
      n_hits  = n_hits + RW'(col_rows[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < ROWS; i++)
        if (col_rows[i])
          mem[wr_ptr + AW'(rank[i])] <= {ROW_W'(i), sub_col, mc_idx, ts};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_hit   <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + AW'(n_hits);
      cnt       <= cnt + (accept ? CW'(n_hits) : '0) - CW'(pop);
      out_valid <= pop;
      if (pop) begin
        out_hit <= mem[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && col_valid) |=> cnt <= $past(cnt));
  assert_valid_from_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cnt) != '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_hit));
endmodule

// File: tb/sim_hit_packer_fifo.sv
module sim_hit_packer_fifo;
  logic clk = 0, rst_n = 0, col_valid = 0;
  logic [7:0] col_rows = 0;
  logic [1:0] sub_col = 0;
  logic [2:0] mc_idx = 0;
  logic [3:0] ts = 0;
  logic stall, out_valid;
  logic [11:0] out_hit;

  int checks = 0, failures = 0, cycles = 0;
  logic [11:0] q[$];
  int occ = 0;
  logic exp_valid = 0;
  logic [11:0] exp_hit = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hit_packer_fifo u0 (.clk, .rst_n, .col_valid, .col_rows, .sub_col, .mc_idx, .ts,
                      .stall, .out_valid, .out_hit);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model from the requirements
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); occ = 0; exp_valid = 0; exp_hit = 0;
    end else begin
      bit acc;
      int n;
      acc = col_valid && (occ <= 8);
      n = acc ? $countones(col_rows) : 0;
      exp_valid = (occ != 0);
      if (exp_valid && q.size() > 0) exp_hit = q.pop_front();
      if (acc)
        for (int r = 0; r < 8; r++)
          if (col_rows[r]) q.push_back({r[2:0], sub_col, mc_idx, ts});
      occ = occ + n - (exp_valid ? 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == exp_valid, "R4/R9 out_valid", out_valid, exp_valid);
      chk(out_hit == exp_hit, "R2/R3/R5/R7/R8 out_hit", out_hit, exp_hit);
      chk(stall == (occ > 8), "R6 stall", stall, occ > 8);
    end
  end

  task automatic send_col(input logic [7:0] r, input logic [1:0] s,
                          input logic [2:0] m, input logic [3:0] t);
    @(negedge clk);
    col_rows = r; sub_col = s; mc_idx = m; ts = t; col_valid = 1;
    @(posedge clk);
    #1 col_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && stall == 0 && out_hit == 0, "R1 in reset",
        {out_valid, stall, out_hit}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && stall == 0 && out_hit == 0, "R1 after reset",
        {out_valid, stall, out_hit}, 0);
  endtask

  task automatic t_single;
    send_col(8'b0010_0000, 2'd2, 3'd6, 4'd9);
    @(negedge clk);
    chk(out_valid == 0, "R4 not yet after edge k", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1 && out_hit == 12'b101_10_110_1001, "R2 R4 single word",
        out_hit, 12'b101_10_110_1001);
    idle(4);
  endtask

  task automatic t_full;
    send_col(8'hFF, 2'd1, 3'd3, 4'd4);
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      chk(out_valid && out_hit == {r[2:0], 2'd1, 3'd3, 4'd4}, "R3 ascending rows",
          out_hit, {r[2:0], 2'd1, 3'd3, 4'd4});
    end
    idle(3);
  endtask

  task automatic t_empty;
    send_col(8'h00, 2'd0, 3'd1, 4'd2);
    idle(4);
    chk(out_valid == 0, "R9 empty column", out_valid, 0);
  endtask

  task automatic t_mixed;
    send_col(8'hA5, 2'd3, 3'd7, 4'd1);
    send_col(8'h3C, 2'd0, 3'd2, 4'd15);
    idle(12);
  endtask

  task automatic t_burst;
    for (int k = 0; k < 6; k++) send_col(8'hFF, k[1:0], k[2:0], 4'(k + 8));
    send_col(8'h81, 2'd2, 3'd5, 4'd3);
    idle(30);
  endtask

  task automatic t_drain;
    logic [11:0] held;
    held = out_hit;
    idle(5);
    chk(out_valid == 0 && out_hit == held, "R8 hold when empty", out_hit, held);
    chk(stall == 0, "R6 stall low when drained", stall, 0);
  endtask

  initial begin
    t_reset;
    t_single;
    t_full;
    t_empty;
    t_mixed;
    t_burst;
    t_burst;
    t_drain;
    chk(q.size() == 0, "R5 all words delivered", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule